// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port behind a simple single-cycle register interface. Software stores an output value and a per-pin direction; a pad is driven only where its direction bit is set. The current pad level comes back through a read-only pad-level register, after a two-flop synchronizer. A read of the output register returns the stored value, never the pad.

Every pin has its own trigger detector. A 2-bit trigger field selects low level, high level, rising edge or falling edge. The fields for the lower sixteen pins sit in one configuration register and those for the upper sixteen in another. A separate per-pin dual-edge bit overrides the field so that the pin reacts to any change. Detected events latch into a status register whose bits software clears by writing ones. A mask register gates the status onto three interrupt lines: one for the lower half, one for the upper half, and one for all pins.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the output, direction, both trigger configuration, mask and dual-edge registers read zero, and pad_oe, irq_lo, irq_hi and irq_any are 0.
- R2: Registers are at byte offsets 0x00 output value, 0x04 direction, 0x08 pad level (read-only), 0x0C trigger config for pins 0-15, 0x10 trigger config for pins 16-31, 0x14 mask, 0x18 status, 0x1C dual-edge select. Writing to 0x08 has no effect. An access with reg_addr[1:0] nonzero is ignored and reads 0. Reads are combinational while reg_re is 1, and read 0 otherwise.
- R3: pad_oe equals the direction register and pad_out equals the output register. Reading 0x00 returns the stored value whatever the pad level.
- R4: A pad level applied before clock edge k is returned by a read of 0x08 after edge k+1.
- R5: Pin n takes its trigger field from bits [2*(n mod 16)+1 : 2*(n mod 16)] of the config register for its half. Code 0 is low level, 1 is high level, 2 is rising edge and 3 is falling edge. A pad change applied before edge k sets the status bit at edge k+2.
- R6: When a pin's dual-edge bit is 1, it reports both rising and falling edges and its trigger field is ignored.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a detection and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: A level-triggered status bit sets again on every cycle the level holds, so a clear only lasts once the synchronized input has left the active level.
- R9: irq_lo is the OR of pending pins 0-15, irq_hi is the OR of pending pins 16-31, and irq_any is the OR of all pending pins. A pin is pending when both its status bit and its mask bit are 1.
- R10: A status bit with mask 0 does not raise any interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, combinational |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_out | output | 32 | Output value toward the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Pending interrupt among pins 0-15 |
| irq_hi | output | 1 | Pending interrupt among pins 16-31 |
| irq_any | output | 1 | Pending interrupt among all pins |

## Verification
The assertions assume that reg_we is a clean one-cycle strobe and that reset puts every register at zero. Under that assumption each status bit can drop only on a write-1 clear and must rise after any detection. The bench changes pad_in only at the falling clock edge, so the synchronizer never sees a change on its sampling edge. It drives register accesses one at a time and mixes random pad activity with random writes to every register, including status clears that collide with detections.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned REG_IDX_W = 3;

  localparam logic [REG_IDX_W-1:0] IDX_DOUT  = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_DIR   = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_LEVEL = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_CFGL  = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_CFGH  = 3'd4;
  localparam logic [REG_IDX_W-1:0] IDX_MASK  = 3'd5;
  localparam logic [REG_IDX_W-1:0] IDX_STAT  = 3'd6;
  localparam logic [REG_IDX_W-1:0] IDX_DUAL  = 3'd7;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  // Decide whether one pin reports an event this cycle.
  function automatic logic trig_hit(input trig_e mode, input logic dual,
                                    input logic now_v, input logic was_v);
    logic hit;
    if (dual) begin
      hit = now_v ^ was_v;
    end else begin
      unique case (mode)
        TRIG_LOW:  hit = ~now_v;
        TRIG_HIGH: hit = now_v;
        TRIG_RISE: hit = now_v & ~was_v;
        default:   hit = ~now_v & was_v;
      endcase
    end
    return hit;
  endfunction

  // New status: clear by written ones, then set by events (set wins).
  function automatic logic [31:0] stat_next(input logic [31:0] cur,
                                            input logic [31:0] clr,
                                            input logic [31:0] set);
    return (cur & ~clr) | set;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_trig_bank.sv
module gpio_trig_bank
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 32,
  localparam int unsigned HALF = PINS / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] lvl_now,
  input  logic [2*HALF-1:0] cfg_lo,
  input  logic [2*HALF-1:0] cfg_hi,
  input  logic [PINS-1:0] dual_sel,
  output logic [PINS-1:0] evt
);
  logic [PINS-1:0] lvl_was;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_was <= '0;
    else        lvl_was <= lvl_now;
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    trig_e mode;
    if (p < HALF) begin : g_lo
      assign mode = trig_e'(cfg_lo[2*p +: 2]);
    end else begin : g_hi
      assign mode = trig_e'(cfg_hi[2*(p-HALF) +: 2]);
    end
    assign evt[p] = trig_hit(mode, dual_sel[p], lvl_now[p], lvl_was[p]);
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS = 32,
  parameter int unsigned AW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic [PINS-1:0] reg_wdata,
  input  logic            reg_we,
  input  logic            reg_re,
  output logic [PINS-1:0] reg_rdata,
  input  logic [PINS-1:0] lvl_now,
  input  logic [PINS-1:0] evt,
  output logic [PINS-1:0] dout_q,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] cfgl_q,
  output logic [PINS-1:0] cfgh_q,
  output logic [PINS-1:0] mask_q,
  output logic [PINS-1:0] stat_q,
  output logic [PINS-1:0] dual_q,
  output logic [PINS-1:0] clr_vec
);
  logic                 aligned;
  logic [REG_IDX_W-1:0] idx;
  logic                 wr_ok;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign idx     = reg_addr[AW-1:2];
  assign wr_ok   = reg_we & aligned;
  assign clr_vec = (wr_ok && idx == IDX_STAT) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      cfgl_q <= '0;
      cfgh_q <= '0;
      mask_q <= '0;
      dual_q <= '0;
    end else if (wr_ok) begin
      unique case (idx)
        IDX_DOUT: dout_q <= reg_wdata;
        IDX_DIR:  dir_q  <= reg_wdata;
        IDX_CFGL: cfgl_q <= reg_wdata;
        IDX_CFGH: cfgh_q <= reg_wdata;
        IDX_MASK: mask_q <= reg_wdata;
        IDX_DUAL: dual_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_next(stat_q, clr_vec, evt);
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_re && aligned) begin
      unique case (idx)
        IDX_DOUT:  reg_rdata = dout_q;
        IDX_DIR:   reg_rdata = dir_q;
        IDX_LEVEL: reg_rdata = lvl_now;
        IDX_CFGL:  reg_rdata = cfgl_q;
        IDX_CFGH:  reg_rdata = cfgh_q;
        IDX_MASK:  reg_rdata = mask_q;
        IDX_STAT:  reg_rdata = stat_q;
        default:   reg_rdata = dual_q;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
  parameter int unsigned PINS = 32,
  localparam int unsigned HALF = PINS / 2
) (
  input  logic [PINS-1:0] stat,
  input  logic [PINS-1:0] mask,
  output logic            irq_lo,
  output logic            irq_hi,
  output logic            irq_any
);
  logic [PINS-1:0] pend;
  assign pend    = stat & mask;
  assign irq_lo  = |pend[HALF-1:0];
  assign irq_hi  = |pend[PINS-1:HALF];
  assign irq_any = |pend;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned PINS       = 32,
  parameter int unsigned AW         = 5,
  parameter int unsigned SYNC_DEPTH = 2,
  localparam int unsigned HALF      = PINS / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic [PINS-1:0] reg_wdata,
  input  logic            reg_we,
  input  logic            reg_re,
  output logic [PINS-1:0] reg_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            irq_lo,
  output logic            irq_hi,
  output logic            irq_any
);
  logic [PINS-1:0] lvl_now;
  logic [PINS-1:0] evt;
  logic [PINS-1:0] dout_q, dir_q, cfgl_q, cfgh_q, mask_q, stat_q, dual_q;
  logic [PINS-1:0] clr_vec;

  gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .q_out(lvl_now)
  );

  gpio_trig_bank #(.PINS(PINS)) u_trig (
    .clk(clk), .rst_n(rst_n), .lvl_now(lvl_now),
    .cfg_lo(cfgl_q[2*HALF-1:0]), .cfg_hi(cfgh_q[2*HALF-1:0]),
    .dual_sel(dual_q), .evt(evt)
  );

  gpio_regfile #(.PINS(PINS), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .lvl_now(lvl_now), .evt(evt),
    .dout_q(dout_q), .dir_q(dir_q), .cfgl_q(cfgl_q), .cfgh_q(cfgh_q),
    .mask_q(mask_q), .stat_q(stat_q), .dual_q(dual_q), .clr_vec(clr_vec)
  );

  gpio_irq_combine #(.PINS(PINS)) u_irq (
    .stat(stat_q), .mask(mask_q),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
  );

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int unsigned PINS = 32,
  localparam int unsigned HALF = PINS / 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [PINS-1:0] evt,
  input logic [PINS-1:0] clr_vec,
  input logic [PINS-1:0] stat_q,
  input logic [PINS-1:0] mask_q,
  input logic [PINS-1:0] pad_oe,
  input logic            irq_lo,
  input logic            irq_hi,
  input logic            irq_any
);
  // R5: a detection is visible in status on the next cycle
  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat_q & $past(evt)) == $past(evt)));

  // R7: a status bit only drops where a one was written to it
  a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(clr_vec)) == '0));

  // R10: no interrupt line without an unmasked status bit
  a_r10_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ((stat_q & mask_q) != '0));

  // R9: the upper line reflects only the upper half
  a_r9_hi_from_upper: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> ((stat_q[PINS-1:HALF] & mask_q[PINS-1:HALF]) != '0));

  // R9: the lower line reflects only the lower half
  a_r9_lo_from_lower: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> ((stat_q[HALF-1:0] & mask_q[HALF-1:0]) != '0));

  // R3: the output enables move only on a write
  a_r3_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(pad_oe));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .evt(evt), .clr_vec(clr_vec),
  .stat_q(stat_q), .mask_q(mask_q), .pad_oe(pad_oe),
  .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi, irq_any;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_port uut (.*);

  // ---------------- behavioural reference ----------------
  logic [31:0] m_dout, m_dir, m_c1, m_c2, m_mask, m_stat, m_dual;
  logic [31:0] m_s1, m_cur, m_prev;

  always @(posedge clk) begin : model
    logic [31:0] hit, clr;
    if (!rst_n) begin
      m_dout = 0; m_dir = 0; m_c1 = 0; m_c2 = 0; m_mask = 0;
      m_stat = 0; m_dual = 0; m_s1 = 0; m_cur = 0; m_prev = 0;
    end else begin
      for (int p = 0; p < 32; p++) begin
        int code;
        code = (p < 16) ? int'((m_c1 >> (2*p)) & 32'd3)
                        : int'((m_c2 >> (2*(p-16))) & 32'd3);
        if (m_dual[p]) hit[p] = (m_cur[p] != m_prev[p]);
        else if (code == 0) hit[p] = (m_cur[p] == 1'b0);
        else if (code == 1) hit[p] = (m_cur[p] == 1'b1);
        else if (code == 2) hit[p] = m_cur[p] && !m_prev[p];
        else hit[p] = !m_cur[p] && m_prev[p];
      end
      clr = (reg_we && reg_addr == 5'h18) ? reg_wdata : 32'h0;
      m_stat = (m_stat & ~clr) | hit;
      m_prev = m_cur; m_cur = m_s1; m_s1 = pad_in;
      if (reg_we) begin
        if (reg_addr == 5'h00) m_dout = reg_wdata;
        if (reg_addr == 5'h04) m_dir  = reg_wdata;
        if (reg_addr == 5'h0C) m_c1   = reg_wdata;
        if (reg_addr == 5'h10) m_c2   = reg_wdata;
        if (reg_addr == 5'h14) m_mask = reg_wdata;
        if (reg_addr == 5'h1C) m_dual = reg_wdata;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [4:0] a);
    if (a == 5'h00) return m_dout;
    if (a == 5'h04) return m_dir;
    if (a == 5'h08) return m_cur;
    if (a == 5'h0C) return m_c1;
    if (a == 5'h10) return m_c2;
    if (a == 5'h14) return m_mask;
    if (a == 5'h18) return m_stat;
    if (a == 5'h1C) return m_dual;
    return 32'h0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin : cmp
      logic [31:0] pend;
      pend = m_stat & m_mask;
      chk("R9 irq_lo", {31'd0, irq_lo}, {31'd0, |pend[15:0]});
      chk("R9 irq_hi", {31'd0, irq_hi}, {31'd0, |pend[31:16]});
      chk("R9 irq_any", {31'd0, irq_any}, {31'd0, |pend});
      chk("R3 pad_oe", pad_oe, m_dir);
      chk("R3 pad_out", pad_out, m_dout);
      chk("R2 rdata", reg_rdata, reg_re ? m_read(reg_addr) : 32'h0);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(posedge clk); #2;
    d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    chk("R1 irq_any", {31'd0, irq_any}, 32'h0);
    chk("R1 pad_oe", pad_oe, 32'h0);
    rd(5'h00, v); chk("R1 dout", v, 32'h0);
    rd(5'h0C, v); chk("R1 cfg lo", v, 32'h0);
    rd(5'h14, v); chk("R1 mask", v, 32'h0);
    rd(5'h1C, v); chk("R1 dual", v, 32'h0);

    wr(5'h14, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);

    // R3: direction and output value, readback is stored value
    wr(5'h04, 32'hFFFF_0000);
    wr(5'h00, 32'h1234_ABCD);
    pad_in = 32'h0F0F_0F0F;
    idle(3);
    chk("R3 pad_oe upper", pad_oe, 32'hFFFF_0000);
    rd(5'h00, v); chk("R3 dout readback", v, 32'h1234_ABCD);

    // R4: pad level visible through pad-level register
    rd(5'h08, v); chk("R4 level", v, 32'h0F0F_0F0F);
    // R2: pad-level register ignores writes; misaligned access ignored
    wr(5'h08, 32'hDEAD_BEEF);
    rd(5'h08, v); chk("R2 level ro", v, 32'h0F0F_0F0F);
    wr(5'h15, 32'hFFFF_FFFF);
    rd(5'h14, v); chk("R2 misaligned write", v, 32'h0);
    rd(5'h01, v); chk("R2 misaligned read", v, 32'h0);

    // R5/R7/R8: pin 0 high level, pin 17 rising edge
    pad_in = 32'h0;
    wr(5'h0C, 32'h0000_0001);          // pin 0 code 1
    wr(5'h10, 32'h0000_0008);          // pin 17 code 2
    wr(5'h14, 32'h0002_0001);
    idle(3);
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, v); chk("R7 cleared, low-level pins reset", v & 32'h0002_0001, 32'h0);
    @(negedge clk); pad_in = 32'h0002_0001;
    idle(4);
    rd(5'h18, v); chk("R5 high+rise set", v & 32'h0002_0001, 32'h0002_0001);
    chk("R9 both lines", {30'd0, irq_hi, irq_lo}, 32'h3);
    wr(5'h18, 32'h0002_0001);
    rd(5'h18, v); chk("R8 level re-sets, edge stays clear", v & 32'h0002_0001, 32'h0000_0001);
    @(negedge clk); pad_in = 32'h0;
    idle(4);
    wr(5'h18, 32'h0000_0001);
    rd(5'h18, v); chk("R8 clear holds once level gone", v & 32'h1, 32'h0);

    // R6: dual-edge on pin 17 overrides rising code
    wr(5'h1C, 32'h0002_0000);
    @(negedge clk); pad_in = 32'h0002_0000;
    idle(4);
    wr(5'h18, 32'h0002_0000);
    @(negedge clk); pad_in = 32'h0;
    idle(4);
    rd(5'h18, v); chk("R6 falling seen in dual mode", v & 32'h0002_0000, 32'h0002_0000);

    // R10: masked status raises nothing
    wr(5'h14, 32'h0);
    chk("R10 masked", {31'd0, irq_any}, 32'h0);

    // random mixed traffic (compared every cycle against the model)
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) pad_in = pad_in ^ (32'h1 << $urandom_range(0, 31));
      reg_we = 1'b0; reg_re = 1'b0;
      case ($urandom_range(0, 5))
        0: begin reg_we = 1'b1; reg_addr = 5'($urandom_range(0, 7) * 4); reg_wdata = $urandom; end
        1: begin reg_we = 1'b1; reg_addr = 5'h18; reg_wdata = $urandom; end
        2, 3: begin reg_re = 1'b1; reg_addr = 5'($urandom_range(0, 7) * 4); end
        default: ;
      endcase
    end
    @(negedge clk); reg_we = 1'b0; reg_re = 1'b0;
    idle(2);
    done = 1'b1;
    #1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule